// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates two independent pulse-width-modulated outputs under control of a small word-addressed register file. One shared control word holds a ten-bit field group per channel. Each channel also has its own period/duty word. A channel divides the system clock by a divisor chosen from a fixed table, which includes reserved codes and a divide-by-one code. It then runs an eight-bit cycle counter across a programmable period and drives its output to the active level while the counter is below the duty count.

Period/duty writes are double buffered. A write lands in a shadow copy and raises the channel's ready flag in the control word. The shadow moves into the working copy at the next period boundary, or on the next cycle if the channel is stopped, and the flag drops in that same cycle. Each channel also supports output polarity, a gate bit and an enable bit that must both be set, a bypass that passes the system clock straight to the pin, and a single-pulse mode whose trigger bit clears itself.

Top module: `pwm2_prescaled`

## Requirements
- R1: After reset the control word (select 0) reads 0 and both outputs sit at the inverted-polarity inactive level, which is high.
- R2: Channel c's control field is at bits [c*15+9 : c*15] of the control word: prescale code [3:0], enable 4, active level 5, gate 6, single-pulse mode 7, pulse trigger 8, bypass 9. The fields read back as written, and channel 1's field drives only pwm_o[1].
- R3: Prescale codes 0..4 divide by 120/180/240/360/480, codes 8..12 divide by 12000/24000/36000/48000/72000, and code 15 divides by 1. Codes 5..7, 13 and 14 stop the channel with its output inactive.
- R4: The period/duty word (select 1 for channel 0, select 2 for channel 1) holds duty in bits [7:0] and period-minus-one P in bits [23:16]. In every P+1 prescaled ticks the output is active for min(duty, P+1) ticks, starting at the period boundary.
- R5: Active-level bit 1 makes the active level high; bit 0 makes it low.
- R6: The counter runs only when enable and gate are both 1. Otherwise the output stays inactive and the count restarts from 0.
- R7: A period/duty write to a running channel sets ready bit 28+c. The new values take effect at the next period boundary, and the flag clears on that same cycle.
- R8: A period/duty write to a stopped channel takes effect on the following cycle, with the ready flag visible for exactly that one cycle.
- R9: A period/duty write on the same cycle as a boundary load leaves the flag set. The previously pending value is used for the coming period, and the new value is used from the boundary after that.
- R10: With bypass set, the output equals the system clock, regardless of prescale, counter and duty.
- R11: With mode set and pulse clear, the output stays inactive. Writing pulse 1 gives exactly one active burst of duty ticks, after which the pulse bit reads 0.
- R12: The ready bits are read-only, so writing ones to them does not set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler source and the bypass signal |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Word select: 0 control, 1 channel 0 period/duty, 2 channel 1 period/duty |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the selected word |
| pwm_o | output | 2 | PWM outputs, one per channel |

## Verification
The collision that matters is between a software write to the period/duty word and the hardware's boundary load of that same word. The bench counts clock edges from the enable write so that a second write lands exactly on the boundary edge, with an earlier write still pending. It then checks that the ready flag stays set, that the first pending duty shapes the next period, and that the colliding duty shapes the period after it, with the flag low only once that second load has happened.

// File: rtl/pwm2_prescaled.sv
module pwm2_prescaled #(
  parameter int NCH      = 2,
  parameter int CH_SHIFT = 15,
  parameter int RDY_BIT  = 28,
  parameter int CW       = 8,
  parameter int DIVW     = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     reg_sel,
  input  logic           bus_wr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_o
);
  localparam int FW = 10;

  function automatic logic [DIVW-1:0] div_of(input logic [3:0] code);
    case (code)
      4'd0:    div_of = DIVW'(120);
      4'd1:    div_of = DIVW'(180);
      4'd2:    div_of = DIVW'(240);
      4'd3:    div_of = DIVW'(360);
      4'd4:    div_of = DIVW'(480);
      4'd8:    div_of = DIVW'(12000);
      4'd9:    div_of = DIVW'(24000);
      4'd10:   div_of = DIVW'(36000);
      4'd11:   div_of = DIVW'(48000);
      4'd12:   div_of = DIVW'(72000);
      4'd15:   div_of = DIVW'(1);
      default: div_of = '0;
    endcase
  endfunction

  logic [FW-1:0]   ctl_q [NCH];
  logic [CW-1:0]   dsh_q [NCH];
  logic [CW-1:0]   psh_q [NCH];
  logic [CW-1:0]   dwk_q [NCH];
  logic [CW-1:0]   pwk_q [NCH];
  logic [CW-1:0]   cnt_q [NCH];
  logic [DIVW-1:0] pre_q [NCH];
  logic [DIVW-1:0] div_c [NCH];
  logic [NCH-1:0]  rdy_q, run, tick, wrap, load, act, prd_we;
  logic            ctrl_we;
  logic            unused_wbits;

  assign ctrl_we      = bus_wr && (reg_sel == 2'd0);
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      prd_we[c] = bus_wr && (reg_sel == 2'(c + 1));
      div_c[c]  = div_of(ctl_q[c][3:0]);
      run[c]    = ctl_q[c][4] && ctl_q[c][6] && (div_c[c] != '0) && !ctl_q[c][9]
                  && (!ctl_q[c][7] || ctl_q[c][8]);
      tick[c]   = run[c] && (pre_q[c] == div_c[c] - DIVW'(1));
      wrap[c]   = tick[c] && (cnt_q[c] == pwk_q[c]);
      load[c]   = rdy_q[c] && (wrap[c] || !run[c]);
      act[c]    = run[c] && (cnt_q[c] < dwk_q[c]);
      pwm_o[c]  = ctl_q[c][9] ? clk : (act[c] ? ctl_q[c][5] : !ctl_q[c][5]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (reg_sel == 2'd0) begin
      for (int c = 0; c < NCH; c++) begin
        bus_rdata[c*CH_SHIFT +: FW] = ctl_q[c];
        bus_rdata[RDY_BIT + c]      = rdy_q[c];
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_sel == 2'(c + 1)) begin
          bus_rdata[0  +: CW] = dsh_q[c];
          bus_rdata[16 +: CW] = psh_q[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        ctl_q[c] <= '0;
        dsh_q[c] <= '0;
        psh_q[c] <= '0;
        dwk_q[c] <= '0;
        pwk_q[c] <= '0;
        cnt_q[c] <= '0;
        pre_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ctrl_we)
          ctl_q[c] <= bus_wdata[c*CH_SHIFT +: FW];
        else if (wrap[c] && ctl_q[c][7])
          ctl_q[c][8] <= 1'b0;

        if (prd_we[c]) begin
          dsh_q[c] <= bus_wdata[0 +: CW];
          psh_q[c] <= bus_wdata[16 +: CW];
        end
        if (load[c]) begin
          dwk_q[c] <= dsh_q[c];
          pwk_q[c] <= psh_q[c];
        end

        if (prd_we[c])    rdy_q[c] <= 1'b1;
        else if (load[c]) rdy_q[c] <= 1'b0;

        if (!run[c]) begin
          pre_q[c] <= '0;
          cnt_q[c] <= '0;
        end else if (tick[c]) begin
          pre_q[c] <= '0;
          cnt_q[c] <= wrap[c] ? '0 : cnt_q[c] + CW'(1);
        end else begin
          pre_q[c] <= pre_q[c] + DIVW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= pwk_q[g]);
    p_ready_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prd_we[g] |=> rdy_q[g]);
    p_work_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_q[g] |=> ($stable(dwk_q[g]) && $stable(pwk_q[g])));
    p_stop_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ctl_q[g][4] && ctl_q[g][6]) && !ctl_q[g][9]) |-> (pwm_o[g] == !ctl_q[g][5]));
    p_pulse_self_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q[g][8]) |-> ($past(ctrl_we) || $past(ctl_q[g][7])));
  end
endmodule

// File: tb/tb_pwm2_prescaled.sv
module tb_pwm2_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm2_prescaled dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .bus_wr(bus_wr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o));

  // {period-1, duty, active level}
  localparam logic [16:0] VEC [8] = '{
    {8'd3,   8'd1,   1'b1}, {8'd3, 8'd2, 1'b0}, {8'd7, 8'd0, 1'b1},
    {8'd7,   8'd8,   1'b1}, {8'd7, 8'd200, 1'b0}, {8'd0, 8'd1, 1'b1},
    {8'd255, 8'd128, 1'b1}, {8'd4, 8'd5, 1'b0}
  };

  function automatic logic [31:0] cw(input int code, input bit en, input bit pol,
                                     input bit gate, input bit mode, input bit pulse, input bit byp);
    cw = {22'd0, byp, pulse, mode, gate, pol, en, 4'(code)};
  endfunction

  function automatic logic [31:0] pw(input int p, input int d);
    pw = {8'd0, 8'(p), 8'd0, 8'(d)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_act(input int ch, input bit lvl, input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o[ch] === lvl) k++;
      @(negedge clk);
    end
  endtask

  task automatic setup0(input int p, input int d);
    wr(2'd0, 32'd0);
    wr(2'd1, pw(p, d));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    repeat (3) @(negedge clk);
    check("R1 reset pwm", {30'd0, pwm_o}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d);
    check("R1 reset ctrl", d, 32'd0);
    check("R1 idle pwm", {30'd0, pwm_o}, 32'd3);

    for (int v = 0; v < 8; v++) begin
      int p = int'(VEC[v][16:9]);
      int du = int'(VEC[v][8:1]);
      bit pol = VEC[v][0];
      int e = 2 * ((du < p + 1) ? du : p + 1);
      setup0(p, du);
      wr(2'd0, cw(15, 1, pol, 1, 0, 0, 0));
      count_act(0, pol, 2 * (p + 1), k);
      check("R4 R5 duty vector", 32'(k), 32'(e));
    end

    // R8 stopped-channel write
    wr(2'd0, 32'd0);
    wr(2'd1, pw(3, 1));
    rd(2'd0, d);
    check("R8 ready one cycle", {31'd0, d[28]}, 32'd1);
    @(negedge clk);
    rd(2'd0, d);
    check("R8 ready cleared", {31'd0, d[28]}, 32'd0);

    // R7 running-channel write
    @(negedge clk);
    wr(2'd0, cw(15, 1, 1, 1, 0, 0, 0));
    wr(2'd1, pw(3, 3));
    rd(2'd0, d);
    check("R7 ready set", {31'd0, d[28]}, 32'd1);
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    check("R7 ready cleared at boundary", {31'd0, d[28]}, 32'd0);
    count_act(0, 1, 4, k);
    check("R7 new duty applied", 32'(k), 32'd3);

    // R9 write colliding with boundary load
    setup0(3, 1);
    wr(2'd0, cw(15, 1, 1, 1, 0, 0, 0));
    wr(2'd1, pw(3, 2));
    repeat (2) @(negedge clk);
    wr(2'd1, pw(3, 3));
    rd(2'd0, d);
    check("R9 ready held", {31'd0, d[28]}, 32'd1);
    count_act(0, 1, 4, k);
    check("R9 first pending duty", 32'(k), 32'd2);
    rd(2'd0, d);
    check("R9 ready cleared later", {31'd0, d[28]}, 32'd0);
    count_act(0, 1, 4, k);
    check("R9 colliding duty", 32'(k), 32'd3);

    // R6 enable and gate
    setup0(3, 4);
    wr(2'd0, cw(15, 1, 1, 0, 0, 0, 0));
    count_act(0, 1, 10, k);
    check("R6 gate off", 32'(k), 32'd0);
    wr(2'd0, cw(15, 0, 1, 1, 0, 0, 0));
    count_act(0, 1, 10, k);
    check("R6 enable off", 32'(k), 32'd0);

    // R3 prescaler
    wr(2'd0, cw(5, 1, 1, 1, 0, 0, 0));
    count_act(0, 1, 20, k);
    check("R3 reserved code 5", 32'(k), 32'd0);
    wr(2'd0, cw(13, 1, 1, 1, 0, 0, 0));
    count_act(0, 1, 20, k);
    check("R3 reserved code 13", 32'(k), 32'd0);
    setup0(1, 1);
    wr(2'd0, cw(0, 1, 1, 1, 0, 0, 0));
    count_act(0, 1, 240, k);
    check("R3 divide 120", 32'(k), 32'd120);
    setup0(1, 1);
    wr(2'd0, cw(1, 1, 1, 1, 0, 0, 0));
    count_act(0, 1, 360, k);
    check("R3 divide 180", 32'(k), 32'd180);

    // R10 bypass
    wr(2'd0, 32'd0);
    wr(2'd0, cw(15, 1, 1, 1, 0, 0, 1));
    #1;
    check("R10 bypass low phase", {31'd0, pwm_o[0]}, 32'd0);
    @(posedge clk); #1;
    check("R10 bypass high phase", {31'd0, pwm_o[0]}, 32'd1);
    @(negedge clk);

    // R11 single pulse
    setup0(7, 3);
    wr(2'd0, cw(15, 1, 1, 1, 1, 0, 0));
    count_act(0, 1, 10, k);
    check("R11 mode idle", 32'(k), 32'd0);
    wr(2'd0, cw(15, 1, 1, 1, 1, 1, 0));
    count_act(0, 1, 30, k);
    check("R11 one pulse", 32'(k), 32'd3);
    rd(2'd0, d);
    check("R11 pulse bit cleared", {31'd0, d[8]}, 32'd0);

    // R2 channel 1 field and isolation
    wr(2'd0, 32'd0);
    wr(2'd2, pw(3, 2));
    @(negedge clk);
    wr(2'd0, cw(15, 1, 1, 1, 0, 0, 0) << 15);
    count_act(1, 1, 8, k);
    check("R2 channel 1 duty", 32'(k), 32'd4);
    count_act(0, 1, 8, k);
    check("R2 channel 0 untouched", 32'(k), 32'd8);

    // R2 readback and R12 read-only ready bits
    wr(2'd0, 32'h3000_0000 | (32'h2AF << 15) | 32'h06A);
    rd(2'd0, d);
    check("R2 R12 readback", d, (32'h2AF << 15) | 32'h06A);
    wr(2'd0, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule